// File: doc/BRIEF.md
# Privileged-Mode Interrupt Priority Selector

This block keeps one pending flag for each of seven interrupt sources and, in every cycle, names the single source that the processor should take next. Sources are raised one at a time through a post strobe that carries a 3-bit source code. Which pending source wins depends on the processor state inputs: the hypervisor-privilege bit, the trap-level-zero enable, the interrupt-enable bit, the current trap level, the processor interrupt level and the software-interrupt register.

The choice is combinational from the registered flags and the state inputs. The chosen cause and, for software interrupts, the level are valid in the same cycle. When the core asserts take while a cause is presented, the flag for that cause is cleared at the next clock edge. The software-interrupt flag is the exception: it stays set while other level bits remain set in the software-interrupt register. An any-pending output tells the core that something is waiting, whatever the enable bits say. A post of an undefined code raises an error pulse.

The selector has two modes, named after the privilege bit. In MODE_HYP, only the hypervisor tick and the interrupt vector can be chosen. In MODE_SUP, the full ordered scan runs. There is no sequential state beyond the seven flags and the error pulse. The mode is re-evaluated every cycle, and moving between modes costs no cycles.

Top module: `intr_prio_sel`

## Requirements
- R1: Source codes are 0 trap-level-zero, 1 hypervisor tick, 2 interrupt vector, 3 CPU mondo, 4 device mondo, 5 resumable error, 6 software interrupt. A post with code 7 sets no flag, and `post_err` is high in the cycle after it (low after any other cycle).
- R2: `any_pending` is high exactly when at least one flag is set, independent of `hpriv`, `tlz_en`, `int_en`, trap level and interrupt level. Reset clears every flag, and all outputs read 0.
- R3: With `hpriv`=1, only code 1 and then code 2 can be selected, and only while `int_en`=1. Otherwise `sel_valid` is 0.
- R4: With `hpriv`=0, code 0 is checked first. It is selected only when `tlz_en`=1 and `trap_lvl`=0, and otherwise it stays pending while the scan continues.
- R5: With `hpriv`=0, code 1 is checked second and is selected even when `int_en`=0.
- R6: With `hpriv`=0 and `int_en`=1, the rest of the order is code 3, code 4, the software-interrupt step, then code 5. With `int_en`=0, none of these is selected.
- R7: At the software-interrupt step, if the software level is below 6 and code 2 is pending, code 2 is selected instead.
- R8: Otherwise the software interrupt (code 6) is selected only when its level is strictly greater than `pil`, and `sel_level` then carries that level. If it is not selected, the scan goes on to code 5. `sel_level` is 0 whenever code 6 is not selected.
- R9: The software level is the index of the highest set bit among `softint` bits 15 down to 1. Bit 0 is ignored, and no set bit gives level 0.
- R10: Taking code 6 clears its flag only when no `softint` bit in 15..1 other than the delivered level remains set.
- R11: Taking any other selected code clears exactly that flag. `take` with `sel_valid`=0 changes no flag.
- R12: A post and a clear of the same source in one cycle leave the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| post_valid | input | 1 | Post strobe |
| post_code | input | 3 | Source code to post |
| take | input | 1 | Core takes the presented cause this cycle |
| hpriv | input | 1 | Hypervisor-privileged mode |
| tlz_en | input | 1 | Trap-level-zero enable |
| int_en | input | 1 | Interrupt enable |
| trap_lvl | input | 3 | Current trap level |
| pil | input | 4 | Processor interrupt level |
| softint | input | 16 | Software-interrupt register |
| sel_valid | output | 1 | A cause is presented |
| sel_cause | output | 3 | Presented source code |
| sel_level | output | 4 | Software level when the cause is 6, else 0 |
| any_pending | output | 1 | At least one flag set |
| post_err | output | 1 | Previous cycle posted an undefined code |

## Verification
The checker assumes that `take` is acted on only together with the cause presented in the same cycle. It also assumes that `softint` and `pil` are steady around the clock edge, so the clear rule for code 6 sees the same level that was presented. The stimulus drives all inputs once per cycle at the falling edge. It draws each state bit, `softint` pattern and post code from a seeded generator, with code 7 kept rare. Directed runs cover the multi-bit software register, post-during-clear and take without a selection.

// File: rtl/intr_prio_pkg.sv
package intr_prio_pkg;

    localparam int NUM_SRC = 7;
    localparam int CODE_W  = 3;

    typedef enum logic [CODE_W-1:0] {
        CZ_TLZ   = 3'd0,
        CZ_HTICK = 3'd1,
        CZ_VEC   = 3'd2,
        CZ_CPUQ  = 3'd3,
        CZ_DEVQ  = 3'd4,
        CZ_RERR  = 3'd5,
        CZ_SOFT  = 3'd6
    } cause_e;

    typedef enum logic {
        MODE_SUP = 1'b0,
        MODE_HYP = 1'b1
    } mode_e;

endpackage

// File: rtl/soft_level_enc.sv
module soft_level_enc #(
    parameter int SOFT_W = 16,
    localparam int LVL_W = $clog2(SOFT_W)
) (
    input  logic [SOFT_W-1:0] softint,
    output logic [LVL_W-1:0]  level,
    output logic              others_left
);
    logic [SOFT_W-1:0] masked;

    always_comb begin
        level = '0;
        for (int i = 1; i < SOFT_W; i++) begin
            if (softint[i]) level = LVL_W'(i);
        end
    end

    always_comb begin
        masked = softint;
        masked[0] = 1'b0;
        masked[level] = 1'b0;
        others_left = |masked;
    end
endmodule

// File: rtl/pend_store.sv
module pend_store
    import intr_prio_pkg::*;
#(
    parameter int NSRC = NUM_SRC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_vec,
    input  logic [NSRC-1:0] clr_vec,
    input  logic            bad_post,
    output logic [NSRC-1:0] pend_q,
    output logic            err_q
);
    for (genvar g = 0; g < NSRC; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n) pend_q[g] <= 1'b0;
            else        pend_q[g] <= (pend_q[g] & ~clr_vec[g]) | set_vec[g];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= bad_post;
    end
endmodule

// File: rtl/prio_pick.sv
module prio_pick
    import intr_prio_pkg::*;
#(
    parameter int LVL_W   = 4,
    parameter int TL_W    = 3,
    parameter int VEC_CUT = 6
) (
    input  logic [NUM_SRC-1:0] pend,
    input  mode_e              mode,
    input  logic               tlz_en,
    input  logic               int_en,
    input  logic [TL_W-1:0]    trap_lvl,
    input  logic [LVL_W-1:0]   pil,
    input  logic [LVL_W-1:0]   soft_lvl,
    output logic               pick_valid,
    output cause_e             pick_cause,
    output logic [LVL_W-1:0]   pick_level
);
    localparam logic [LVL_W-1:0] CUT = LVL_W'(VEC_CUT);

    always_comb begin
        pick_valid = 1'b0;
        pick_cause = CZ_TLZ;
        pick_level = '0;
        unique case (mode)
            MODE_HYP: begin
                if (int_en) begin
                    if (pend[CZ_HTICK]) begin
                        pick_valid = 1'b1;
                        pick_cause = CZ_HTICK;
                    end else if (pend[CZ_VEC]) begin
                        pick_valid = 1'b1;
                        pick_cause = CZ_VEC;
                    end
                end
            end
            MODE_SUP: begin
                if (pend[CZ_TLZ] && tlz_en && (trap_lvl == '0)) begin
                    pick_valid = 1'b1;
                    pick_cause = CZ_TLZ;
                end else if (pend[CZ_HTICK]) begin
                    pick_valid = 1'b1;
                    pick_cause = CZ_HTICK;
                end else if (int_en) begin
                    if (pend[CZ_CPUQ]) begin
                        pick_valid = 1'b1;
                        pick_cause = CZ_CPUQ;
                    end else if (pend[CZ_DEVQ]) begin
                        pick_valid = 1'b1;
                        pick_cause = CZ_DEVQ;
                    end else if (pend[CZ_SOFT] && (soft_lvl < CUT) && pend[CZ_VEC]) begin
                        pick_valid = 1'b1;
                        pick_cause = CZ_VEC;
                    end else if (pend[CZ_SOFT] && (soft_lvl > pil)) begin
                        pick_valid = 1'b1;
                        pick_cause = CZ_SOFT;
                        pick_level = soft_lvl;
                    end else if (pend[CZ_RERR]) begin
                        pick_valid = 1'b1;
                        pick_cause = CZ_RERR;
                    end
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/intr_prio_sel.sv
module intr_prio_sel
    import intr_prio_pkg::*;
#(
    parameter int SOFT_W  = 16,
    parameter int TL_W    = 3,
    parameter int VEC_CUT = 6,
    localparam int LVL_W  = $clog2(SOFT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              post_valid,
    input  logic [CODE_W-1:0] post_code,
    input  logic              take,
    input  logic              hpriv,
    input  logic              tlz_en,
    input  logic              int_en,
    input  logic [TL_W-1:0]   trap_lvl,
    input  logic [LVL_W-1:0]  pil,
    input  logic [SOFT_W-1:0] softint,
    output logic              sel_valid,
    output logic [CODE_W-1:0] sel_cause,
    output logic [LVL_W-1:0]  sel_level,
    output logic              any_pending,
    output logic              post_err
);
    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] set_vec;
    logic [NUM_SRC-1:0] clr_vec;
    logic               bad_post;
    logic [LVL_W-1:0]   soft_lvl;
    logic               soft_more;
    cause_e             pick_cause;
    mode_e              mode;

    assign mode = hpriv ? MODE_HYP : MODE_SUP;

    always_comb begin
        set_vec  = '0;
        bad_post = 1'b0;
        if (post_valid) begin
            if (post_code < CODE_W'(NUM_SRC)) set_vec[post_code] = 1'b1;
            else                              bad_post = 1'b1;
        end
    end

    always_comb begin
        clr_vec = '0;
        if (take && sel_valid) begin
            if (pick_cause == CZ_SOFT) clr_vec[CZ_SOFT] = ~soft_more;
            else                       clr_vec[pick_cause] = 1'b1;
        end
    end

    soft_level_enc #(.SOFT_W(SOFT_W)) u_enc (
        .softint     (softint),
        .level       (soft_lvl),
        .others_left (soft_more)
    );

    pend_store #(.NSRC(NUM_SRC)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .clr_vec  (clr_vec),
        .bad_post (bad_post),
        .pend_q   (pend_q),
        .err_q    (post_err)
    );

    prio_pick #(.LVL_W(LVL_W), .TL_W(TL_W), .VEC_CUT(VEC_CUT)) u_pick (
        .pend       (pend_q),
        .mode       (mode),
        .tlz_en     (tlz_en),
        .int_en     (int_en),
        .trap_lvl   (trap_lvl),
        .pil        (pil),
        .soft_lvl   (soft_lvl),
        .pick_valid (sel_valid),
        .pick_cause (pick_cause),
        .pick_level (sel_level)
    );

    assign sel_cause   = pick_cause;
    assign any_pending = |pend_q;
endmodule

// File: rtl/intr_prio_sel_chk.sv
module intr_prio_sel_chk #(
    parameter int LVL_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             post_valid,
    input logic [2:0]       post_code,
    input logic             take,
    input logic             hpriv,
    input logic             int_en,
    input logic [LVL_W-1:0] pil,
    input logic             sel_valid,
    input logic [2:0]       sel_cause,
    input logic [LVL_W-1:0] sel_level,
    input logic             any_pending,
    input logic             post_err,
    input logic [6:0]       pend
);
    // R1
    bad_code_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (post_valid && post_code == 3'd7) |=> post_err);

    // R1
    no_spurious_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(post_valid && post_code == 3'd7) |=> !post_err);

    // R2
    valid_implies_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> any_pending);

    // R3
    hyp_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hpriv && sel_valid) |-> (int_en && (sel_cause == 3'd1 || sel_cause == 3'd2)));

    // R6
    ie_off_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && !int_en) |-> (sel_cause <= 3'd1));

    // R8
    soft_above_pil_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && sel_cause == 3'd6) |-> (sel_level > pil));

    // R11
    take_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && sel_valid && sel_cause != 3'd6 && !(post_valid && post_code == sel_cause))
        |=> !pend[$past(sel_cause)]);

    // R12
    post_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (post_valid && post_code == 3'd1) |=> pend[1]);
endmodule

bind intr_prio_sel intr_prio_sel_chk #(.LVL_W(LVL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .post_valid  (post_valid),
    .post_code   (post_code),
    .take        (take),
    .hpriv       (hpriv),
    .int_en      (int_en),
    .pil         (pil),
    .sel_valid   (sel_valid),
    .sel_cause   (sel_cause),
    .sel_level   (sel_level),
    .any_pending (any_pending),
    .post_err    (post_err),
    .pend        (pend_q)
);

// File: tb/intr_prio_sel_tb_top.sv
`timescale 1ns/1ps
module intr_prio_sel_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        post_valid = 1'b0;
    logic [2:0]  post_code = '0;
    logic        take = 1'b0;
    logic        hpriv = 1'b0;
    logic        tlz_en = 1'b0;
    logic        int_en = 1'b0;
    logic [2:0]  trap_lvl = '0;
    logic [3:0]  pil = '0;
    logic [15:0] softint = '0;
    logic        sel_valid;
    logic [2:0]  sel_cause;
    logic [3:0]  sel_level;
    logic        any_pending;
    logic        post_err;

    int unsigned n_chk = 0;
    int unsigned n_err = 0;
    bit [6:0]    m_pend = '0;
    bit          m_err = 1'b0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    intr_prio_sel dut_i (
        .clk(clk), .rst_n(rst_n), .post_valid(post_valid), .post_code(post_code),
        .take(take), .hpriv(hpriv), .tlz_en(tlz_en), .int_en(int_en),
        .trap_lvl(trap_lvl), .pil(pil), .softint(softint),
        .sel_valid(sel_valid), .sel_cause(sel_cause), .sel_level(sel_level),
        .any_pending(any_pending), .post_err(post_err)
    );

    function automatic bit [3:0] soft_lvl_of(bit [15:0] si);
        bit [3:0] l = 0;
        for (int i = 1; i < 16; i++) if (si[i]) l = 4'(i);
        return l;
    endfunction

    // expected selection: {valid, cause, level}
    function automatic bit [7:0] model_pick(bit [6:0] p);
        bit [3:0] l = soft_lvl_of(softint);
        if (hpriv) begin
            if (int_en && p[1]) return {1'b1, 3'd1, 4'd0};
            if (int_en && p[2]) return {1'b1, 3'd2, 4'd0};
            return 8'd0;
        end
        if (p[0] && tlz_en && trap_lvl == 0) return {1'b1, 3'd0, 4'd0};
        if (p[1]) return {1'b1, 3'd1, 4'd0};
        if (!int_en) return 8'd0;
        if (p[3]) return {1'b1, 3'd3, 4'd0};
        if (p[4]) return {1'b1, 3'd4, 4'd0};
        if (p[6] && l < 6 && p[2]) return {1'b1, 3'd2, 4'd0};
        if (p[6] && l > pil) return {1'b1, 3'd6, l};
        if (p[5]) return {1'b1, 3'd5, 4'd0};
        return 8'd0;
    endfunction

    function automatic string tag_of(bit [7:0] e);
        if (hpriv) return "R3";
        if (!e[7]) return "R6";
        case (e[6:4])
            3'd0: return "R4";
            3'd1: return "R5";
            3'd2: return "R7";
            3'd6: return "R8";
            default: return "R6";
        endcase
    endfunction

    task automatic chk(string req, int act, int exp, string what);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // inputs already driven after a falling edge; check, then clock the model
    task automatic cycle(string req);
        bit [7:0] e;
        bit [6:0] clr = 0, st = 0;
        bit [15:0] rest;
        #1;
        e = model_pick(m_pend);
        chk(req.len() ? req : tag_of(e), int'(sel_valid), int'(e[7]), "sel_valid");
        if (e[7]) chk(req.len() ? req : tag_of(e), int'(sel_cause), int'(e[6:4]), "sel_cause");
        chk("R9", int'(sel_level), int'(e[3:0]), "sel_level");
        chk("R2", int'(any_pending), int'(m_pend != 0), "any_pending");
        chk("R1", int'(post_err), int'(m_err), "post_err");
        if (post_valid && post_code != 3'd7) st[post_code] = 1'b1;
        if (take && e[7]) begin
            if (e[6:4] == 3'd6) begin
                rest = softint;
                rest[0] = 1'b0;
                rest[e[3:0]] = 1'b0;
                clr[6] = (rest == 0);
            end else clr[e[6:4]] = 1'b1;
        end
        @(posedge clk);
        m_pend = (m_pend & ~clr) | st;
        m_err  = post_valid && post_code == 3'd7;
        @(negedge clk);
    endtask

    task automatic drive(bit pv, bit [2:0] pc, bit tk, bit hp, bit tz, bit ie,
                         bit [2:0] tl, bit [3:0] pl, bit [15:0] si);
        post_valid = pv; post_code = pc; take = tk; hpriv = hp; tlz_en = tz;
        int_en = ie; trap_lvl = tl; pil = pl; softint = si;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        #1;
        chk("R2", int'(any_pending), 0, "reset any_pending");
        chk("R2", int'(sel_valid), 0, "reset sel_valid");
        chk("R1", int'(post_err), 0, "reset post_err");
        rst_n = 1'b1;
        @(negedge clk);

        // R1: undefined code sets nothing, pulses error
        drive(1, 3'd7, 0, 0, 1, 1, 0, 0, 0); cycle("R1");
        drive(0, 3'd0, 0, 0, 1, 1, 0, 0, 0); cycle("R1");
        cycle("R1");

        // R4: trap-level-zero held while trap level nonzero
        drive(1, 3'd0, 0, 0, 1, 1, 3'd2, 0, 0); cycle("R4");
        drive(0, 3'd0, 1, 0, 1, 1, 3'd2, 0, 0); cycle("R4");
        drive(0, 3'd0, 1, 0, 1, 1, 3'd0, 0, 0); cycle("R4");

        // R11: take without a selection leaves flags alone
        drive(1, 3'd3, 0, 1, 0, 0, 0, 0, 0); cycle("R11");
        drive(0, 3'd0, 1, 1, 0, 0, 0, 0, 0); cycle("R11");
        drive(0, 3'd0, 1, 0, 0, 1, 0, 0, 0); cycle("R11");

        // R10: soft flag stays while another level bit remains
        drive(1, 3'd6, 0, 0, 0, 1, 0, 4'd2, 16'h0208); cycle("R10");
        drive(0, 3'd0, 1, 0, 0, 1, 0, 4'd2, 16'h0209); cycle("R10");
        drive(0, 3'd0, 1, 0, 0, 1, 0, 4'd2, 16'h0201); cycle("R10");
        drive(0, 3'd0, 0, 0, 0, 1, 0, 4'd2, 16'h0201); cycle("R10");

        // R12: post of hypervisor tick while taking it
        drive(1, 3'd1, 0, 0, 0, 0, 0, 0, 0); cycle("R12");
        drive(1, 3'd1, 1, 0, 0, 0, 0, 0, 0); cycle("R12");
        drive(0, 3'd0, 1, 0, 0, 0, 0, 0, 0); cycle("R12");

        // R7: vector slots in below level 6
        drive(1, 3'd2, 0, 0, 0, 1, 0, 0, 16'h0010); cycle("R7");
        drive(1, 3'd6, 0, 0, 0, 1, 0, 0, 16'h0010); cycle("R7");
        drive(0, 3'd0, 0, 0, 0, 1, 0, 0, 16'h0040); cycle("R8");
        drive(0, 3'd0, 1, 0, 0, 1, 0, 0, 16'h0010); cycle("R7");

        for (int k = 0; k < 4000; k++) begin
            bit [15:0] si;
            bit [2:0]  pc;
            pc = ($urandom % 16 == 0) ? 3'd7 : 3'($urandom % 7);
            case ($urandom % 4)
                0: si = 16'h0;
                1: si = 16'(1) << ($urandom % 16);
                2: si = (16'(1) << ($urandom % 16)) | (16'(1) << ($urandom % 16));
                default: si = 16'($urandom);
            endcase
            drive(($urandom % 3) != 0, pc, ($urandom % 2) == 1, ($urandom % 10) < 3,
                  ($urandom % 2) == 1, ($urandom % 10) < 7,
                  ($urandom % 2) == 1 ? 3'd0 : 3'($urandom), 4'($urandom), si);
            cycle("");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule